// File: doc/BRIEF.md
# Seven-Stage Pipeline Hazard Controller

This block decides, every cycle, whether the front of an in-order seven-stage pipeline must hold or be cleared. The stages run in the order IF1, IF2, ID, EX, ME1, ME2, WB. Instruction fetch takes two stages and memory access takes two, because both caches are pipelined. Load data is therefore only ready at the end of ME2. An instruction in ID that reads a register a load is still fetching must wait. The controller holds IF1, IF2 and ID and sends a bubble into EX until the value can be forwarded.

A branch resolved in EX as mispredicted leaves three wrong-path instructions in IF1, IF2 and ID. The controller flushes all three and asks the fetch unit to redirect. A flush wins over a stall raised in the same cycle. The controller is given the ID source registers, the producer in EX (destination, write enable, load flag) and the branch outcome. It keeps its own one-cycle record of a load moving from EX into ME1. Forwarding muxes, the predictor and the cache arrays live elsewhere.

Top module: `p7_hazard_ctrl`

## Requirements
- R1: When EX holds a load (`ex_wr`=1, `ex_load`=1) whose destination is nonzero and equals an ID source whose use flag is 1 (either source), `hold_if1`, `hold_if2`, `hold_id` and `bubble_ex` are all 1 in that same cycle, unless a flush is raised.
- R2: A load that was in EX in the previous cycle is now in ME1. An ID source matching its nonzero destination causes one more stall cycle. So a dependent instruction directly behind a load sees two stall cycles, and one two slots behind sees one.
- R3: A producer with destination register 0, or with `ex_wr`=0, never causes a stall, now or in the following cycle.
- R4: A non-load producer (`ex_load`=0) in EX never causes a stall, now or in the following cycle.
- R5: `flush_if1`, `flush_if2`, `flush_id` and `redirect` are 1 in the cycle where `br_valid`=1 and `br_mispredict`=1, and 0 otherwise.
- R6: When a flush and a load-use stall coincide, the flush outputs are 1 and all four stall outputs are 0.
- R7: An ID source whose use flag is 0 never matches, even when its number equals a load destination.
- R8: After reset all outputs are 0 and no load is remembered as being in ME1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src1 | input | 5 | First source register of the ID instruction |
| id_use1 | input | 1 | First source is read |
| id_src2 | input | 5 | Second source register of the ID instruction |
| id_use2 | input | 1 | Second source is read |
| ex_dst | input | 5 | Destination register of the EX instruction |
| ex_wr | input | 1 | EX instruction writes a register |
| ex_load | input | 1 | EX instruction is a load |
| br_valid | input | 1 | A branch resolves in EX this cycle |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| hold_if1 | output | 1 | Keep IF1 contents |
| hold_if2 | output | 1 | Keep IF2 contents |
| hold_id | output | 1 | Keep ID contents |
| bubble_ex | output | 1 | Send a bubble into EX |
| flush_if1 | output | 1 | Turn IF1 into a bubble |
| flush_if2 | output | 1 | Turn IF2 into a bubble |
| flush_id | output | 1 | Turn ID into a bubble |
| redirect | output | 1 | Restart fetch on the corrected path |

## Verification
The assertions assume that EX never holds. Whatever sits in EX at one edge is in ME1 at the next, so the internal record of a load in ME1 always follows the EX inputs of the previous cycle. They also assume a bubble shows up as `ex_wr`=0. The stimulus keeps to this. After each stall it replaces the EX inputs with a bubble and keeps the ID sources unchanged, the way a held ID stage would. The bench drives inputs just after each rising edge, and the stall outputs it checks depend on the EX inputs of the step before.

// File: rtl/p7_pkg.sv
package p7_pkg;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned NUM_FE  = 3;

  typedef struct packed {
    logic              live;
    logic [RIDX_W-1:0] dst;
  } ld_slot_t;
endpackage

// File: rtl/p7_src_match.sv
module p7_src_match #(
  parameter int unsigned W = p7_pkg::RIDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         src_use,
  input  logic [W-1:0] dst,
  input  logic         dst_live,
  output logic         hit
);
  always_comb begin
    hit = src_use && dst_live && (dst != '0) && (src == dst);
  end

  assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst == '0) |-> !hit);
  assert_unused_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_use |-> !hit);
endmodule

// File: rtl/p7_load_track.sv
module p7_load_track
  import p7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_is_ld,
  input  logic [RIDX_W-1:0] ex_dst,
  output ld_slot_t          me1_slot
);
  ld_slot_t slot_d, slot_q;

  always_comb begin
    slot_d.live = ex_is_ld && (ex_dst != '0);
    slot_d.dst  = slot_d.live ? ex_dst : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign me1_slot = slot_q;

  assert_nonload_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_ld |=> !me1_slot.live);
endmodule

// File: rtl/p7_flush_unit.sv
module p7_flush_unit #(
  parameter int unsigned NFE = p7_pkg::NUM_FE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           br_valid,
  input  logic           br_mispredict,
  output logic [NFE-1:0] fe_flush,
  output logic           redirect
);
  logic kill;

  always_comb begin
    kill     = br_valid && br_mispredict;
    redirect = kill;
  end

  for (genvar g = 0; g < NFE; g++) begin : g_fe
    assign fe_flush[g] = kill;
  end

  assert_no_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> (fe_flush == '0) && !redirect);
endmodule

// File: rtl/p7_hazard_ctrl.sv
module p7_hazard_ctrl
  import p7_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] id_src1,
  input  logic              id_use1,
  input  logic [RIDX_W-1:0] id_src2,
  input  logic              id_use2,
  input  logic [RIDX_W-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic              br_valid,
  input  logic              br_mispredict,
  output logic              hold_if1,
  output logic              hold_if2,
  output logic              hold_id,
  output logic              bubble_ex,
  output logic              flush_if1,
  output logic              flush_if2,
  output logic              flush_id,
  output logic              redirect
);
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [RIDX_W-1:0]  src_v [NUM_SRC];
  logic               use_v [NUM_SRC];
  logic [NUM_SRC-1:0] hit_ex, hit_me1;
  logic               ex_is_ld;
  ld_slot_t           me1_slot;
  logic [NUM_FE-1:0]  fe_flush;
  logic               load_use, stall;

  assign src_v[0] = id_src1;
  assign src_v[1] = id_src2;
  assign use_v[0] = id_use1;
  assign use_v[1] = id_use2;
  assign ex_is_ld = ex_wr && ex_load;

  p7_load_track i_track (
    .clk(clk), .rst_n(rst_sync_n), .ex_is_ld(ex_is_ld), .ex_dst(ex_dst),
    .me1_slot(me1_slot)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    p7_src_match i_m_ex (
      .clk(clk), .rst_n(rst_sync_n), .src(src_v[s]), .src_use(use_v[s]),
      .dst(ex_dst), .dst_live(ex_is_ld), .hit(hit_ex[s])
    );
    p7_src_match i_m_me1 (
      .clk(clk), .rst_n(rst_sync_n), .src(src_v[s]), .src_use(use_v[s]),
      .dst(me1_slot.dst), .dst_live(me1_slot.live), .hit(hit_me1[s])
    );
  end

  p7_flush_unit i_flush (
    .clk(clk), .rst_n(rst_sync_n), .br_valid(br_valid),
    .br_mispredict(br_mispredict), .fe_flush(fe_flush), .redirect(redirect)
  );

  always_comb begin
    load_use  = (|hit_ex) || (|hit_me1);
    stall     = load_use && !redirect;
    hold_if1  = stall;
    hold_if2  = stall;
    hold_id   = stall;
    bubble_ex = stall;
    flush_if1 = fe_flush[0];
    flush_if2 = fe_flush[1];
    flush_id  = fe_flush[2];
  end

  assert_flush_wins_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flush_if1 || flush_id) |-> !hold_id && !bubble_ex && !hold_if1);
  assert_hold_group_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bubble_ex |-> hold_if1 && hold_if2 && hold_id);
  assert_flush_set_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_valid && br_mispredict) |-> flush_if1 && flush_if2 && flush_id && redirect);
endmodule

// File: tb/test_p7_hazard_ctrl.sv
module test_p7_hazard_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] id_src1, id_src2, ex_dst;
  logic id_use1, id_use2, ex_wr, ex_load, br_valid, br_mispredict;
  logic hold_if1, hold_if2, hold_id, bubble_ex;
  logic flush_if1, flush_if2, flush_id, redirect;

  always #5 clk = ~clk;

  p7_hazard_ctrl i_p7_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_src1(id_src1), .id_use1(id_use1), .id_src2(id_src2), .id_use2(id_use2),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .br_valid(br_valid), .br_mispredict(br_mispredict),
    .hold_if1(hold_if1), .hold_if2(hold_if2), .hold_id(hold_id),
    .bubble_ex(bubble_ex), .flush_if1(flush_if1), .flush_if2(flush_if2),
    .flush_id(flush_id), .redirect(redirect)
  );

  typedef struct {
    logic  st;
    logic  fl;
    string tag;
  } exp_t;

  exp_t exq[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] s1, input logic u1, input logic [4:0] s2,
                      input logic u2, input logic [4:0] d, input logic w, input logic ld,
                      input logic bv, input logic bm, input logic est, input logic efl,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    id_src1 = s1; id_use1 = u1; id_src2 = s2; id_use2 = u2;
    ex_dst = d; ex_wr = w; ex_load = ld; br_valid = bv; br_mispredict = bm;
    e.st = est; e.fl = efl; e.tag = tag;
    exq.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (exq.size() > 0) begin
        e = exq.pop_front();
        check({hold_if1, hold_if2, hold_id, bubble_ex}, {4{e.st}}, {e.tag, " stall"});
        check({flush_if1, flush_if2, flush_id, redirect}, {4{e.fl}}, {e.tag, " flush"});
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0;
    id_src1 = '0; id_use1 = 0; id_src2 = '0; id_use2 = 0;
    ex_dst = '0; ex_wr = 0; ex_load = 0; br_valid = 0; br_mispredict = 0;
    repeat (3) @(posedge clk);
    #1;
    check({hold_if1, hold_if2, hold_id, bubble_ex}, 4'b0, "R8 reset stall");
    check({flush_if1, flush_if2, flush_id, redirect}, 4'b0, "R8 reset flush");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R8: nothing remembered after reset; ID reads r5 with a bubble in EX
    step(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R8 empty tracker");
    // R1 then R2: load r5 followed directly by a user of r5 -> two stalls
    step(5'd5, 1, 5'd0, 0, 5'd5, 1, 1, 0, 0, 1, 0, "R1 ex load src1");
    step(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, 0, 0, 1, 0, "R2 second bubble");
    step(5'd5, 1, 5'd0, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R2 released");
    // R2: user two slots behind load r7 -> one stall
    step(5'd3, 1, 5'd4, 1, 5'd7, 1, 1, 0, 0, 0, 0, "R2 no dep yet");
    step(5'd1, 1, 5'd7, 1, 5'd9, 1, 0, 0, 0, 1, 0, "R2 me1 load src2");
    step(5'd1, 1, 5'd7, 1, 5'd0, 0, 0, 0, 0, 0, 0, "R2 single bubble");
    // R1: second source match
    step(5'd2, 0, 5'd12, 1, 5'd12, 1, 1, 0, 0, 1, 0, "R1 ex load src2");
    step(5'd2, 0, 5'd12, 1, 5'd0, 0, 0, 0, 0, 1, 0, "R1 follow bubble");
    // R3: register 0 and non-writing loads
    step(5'd0, 1, 5'd0, 1, 5'd0, 1, 1, 0, 0, 0, 0, "R3 load to r0");
    step(5'd0, 1, 5'd0, 1, 5'd0, 0, 0, 0, 0, 0, 0, "R3 r0 next cycle");
    step(5'd6, 1, 5'd0, 0, 5'd6, 0, 1, 0, 0, 0, 0, "R3 no write");
    step(5'd6, 1, 5'd0, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R3 no write next");
    // R4: ALU producer is forwarded, no stall
    step(5'd8, 1, 5'd8, 1, 5'd8, 1, 0, 0, 0, 0, 0, "R4 alu in ex");
    step(5'd8, 1, 5'd8, 1, 5'd0, 0, 0, 0, 0, 0, 0, "R4 alu in me1");
    // R7: match without use flag
    step(5'd10, 0, 5'd10, 0, 5'd10, 1, 1, 0, 0, 0, 0, "R7 unused ex");
    step(5'd10, 0, 5'd10, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R7 unused me1");
    // R5: mispredict flush, correct prediction none, mispredict flag alone none
    step(5'd1, 1, 5'd2, 1, 5'd0, 0, 0, 1, 1, 0, 1, "R5 mispredict");
    step(5'd1, 1, 5'd2, 1, 5'd0, 0, 0, 1, 0, 0, 0, "R5 correct branch");
    step(5'd1, 1, 5'd2, 1, 5'd0, 0, 0, 0, 1, 0, 0, "R5 no branch");
    // R6: flush and load-use in the same cycle (ME1 load r11)
    step(5'd3, 1, 5'd4, 0, 5'd11, 1, 1, 0, 0, 0, 0, "R6 setup");
    step(5'd11, 1, 5'd4, 0, 5'd0, 0, 0, 1, 1, 0, 1, "R6 flush wins");
    step(5'd0, 0, 5'd0, 0, 5'd0, 0, 0, 0, 0, 0, 0, "R6 quiet");
    while (exq.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule